// File: doc/BRIEF.md
# Strobed FIFO Controller with Rewind

This block is a first-in, first-out store with one clock. Its write, read and rewind controls are active-low strobes that may come from outside the clock domain. Each strobe passes through a two-flop synchroniser and an edge detector. After that, a falling edge starts an operation and a rising edge finishes it.

A write reserves a slot on its falling edge. It stores the data bus on its rising edge. A read takes the oldest stored word on its falling edge. The read-data bus is driven only while that read is open, and `dout_oe` models the tristate enable for an enclosing pad.

Three active-low status outputs report how much of the queue is used:
- `full_n` tells the writer to stop.
- `empty_n` tells the reader to stop.
- `half_n` asserts when more than half of the queue is in use.

Back-pressure uses only these flags. A write falling edge is refused while `full_n` is low. A read falling edge is refused while `empty_n` is low. A strobe that is held low against a blocking flag is not lost. It completes once the flag clears, which gives write and read flow-through.

A rewind pulse moves the read pointer back to physical location zero, so a block that was already read can be replayed. The pulse is taken only when both the write and read strobes stay high for its whole duration.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, the outputs are `full_n`=1, `half_n`=1, `empty_n`=0 and `dout_oe`=0. Both pointers are at location zero, so earlier contents are lost.
- R2: A write falling edge is accepted only while `full_n` is high. A write edge arriving while the queue is full, with the strobe released before space frees up, stores nothing.
- R3: Reads return words in the order they were written. A read falling edge is accepted only while `empty_n` is high. From one clock after acceptance until the strobe rises, `dout_oe` is 1 and `dout` carries the word. Whenever `dout_oe` is 0, `dout` is all zeros.
- R4: With DEPTH=2048, the flags `{full_n,half_n,empty_n}` follow the unread count as follows:
  - 0 words: 110
  - 1 to 1024 words: 111
  - 1025 to 2047 words: 101
  - 2048 words: 001
- R5: `half_n` falls on the write falling edge that takes the count above DEPTH/2. It rises on the read rising edge that brings the count back to DEPTH/2 or below.
- R6: `full_n` falls on the write falling edge that claims the last slot, and rises only after a read rising edge. `empty_n` falls on the read falling edge that takes the last word, and rises only after a write rising edge or a rewind.
- R7: A rewind pulse (`rt_n` low, then high) sets the read pointer to location zero and leaves the write pointer unchanged. The unread count becomes the write-pointer value, or stays at DEPTH if the queue was full, and the flags follow from that count.
- R8: A rewind pulse during which `wr_n` or `rd_n` is low, or any operation is open, is ignored.
- R9: A read strobe held low while the queue is empty takes the first word written once that write's rising edge is seen, and presents it on `dout`. Later writes do not replace it. The next word needs a new read strobe.
- R10: A write strobe held low while the queue is full completes after a read rising edge. `full_n` rises briefly and then falls again, and the held word is stored on the strobe's rising edge, behind all older words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| rt_n | input | 1 | Active-low rewind strobe, asynchronous |
| din | input | WIDTH | Write data, captured when the write strobe's rising edge is seen |
| dout | output | WIDTH | Read data; zero when not enabled |
| dout_oe | output | 1 | Enable for the read-data bus |
| full_n | output | 1 | Low when all DEPTH slots are claimed |
| half_n | output | 1 | Low when more than DEPTH/2 slots are claimed |
| empty_n | output | 1 | Low when no stored word is available to read |

## Verification
The hardest state to reach is a full queue, because it needs 2048 complete write strobes. Once there, the bench holds a write strobe low against it, opens and closes one read, and watches `full_n` blink high and fall again, then releases the held write. It then drains all 2048 words. It checks that the held word comes out last, that a write refused while full never appears, and that `half_n` rises exactly on the read that brings the count back to 1024. Read flow-through is reached by holding `rd_n` low on an empty queue across two write pulses.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef struct packed {
    logic lvl;   // synchronised strobe level (active low)
    logic fall;  // one-cycle pulse: strobe asserted
    logic rise;  // one-cycle pulse: strobe released
  } strobe_t;

  localparam int STB_WR = 0;
  localparam int STB_RD = 1;
  localparam int STB_RT = 2;
  localparam int NSTB   = 3;
endpackage

// File: rtl/fifo_rt_strobe_sync.sv
module fifo_rt_strobe_sync
  import fifo_rt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_n,
  output strobe_t ev
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign ev.lvl  = s2;
  assign ev.fall = s3 & ~s2;
  assign ev.rise = ~s3 & s2;
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_inc,   // write slot claimed
  input  logic          fill_dec,   // read slot released
  input  logic          avail_inc,  // word committed
  input  logic          avail_dec,  // word taken
  input  logic          rt_load,
  input  logic [AW-1:0] rt_ptr,
  output logic          full_n,
  output logic          half_n,
  output logic          empty_n
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] fill_q, avail_q, rt_cnt;

  assign rt_cnt = (fill_q == FULL_CNT) ? FULL_CNT : {1'b0, rt_ptr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      avail_q <= '0;
    end else if (rt_load) begin
      fill_q  <= rt_cnt;
      avail_q <= rt_cnt;
    end else begin
      fill_q  <= fill_q + CW'(fill_inc) - CW'(fill_dec);
      avail_q <= avail_q + CW'(avail_inc) - CW'(avail_dec);
    end
  end

  assign full_n  = (fill_q != FULL_CNT);
  assign half_n  = (fill_q <= HALF_CNT);
  assign empty_n = (avail_q != '0);
endmodule

// File: rtl/fifo_rt_seq.sv
module fifo_rt_seq
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       wr_ev,
  input  strobe_t       rd_ev,
  input  strobe_t       rt_ev,
  input  logic          full_n,
  input  logic          empty_n,
  output logic          wr_take,
  output logic          wr_commit,
  output logic          rd_take,
  output logic          rd_done,
  output logic          rt_go,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          rd_active
);
  logic wr_active, wr_wait, rd_wait, rt_armed, busy;

  assign busy      = wr_active | wr_wait | rd_active | rd_wait;
  assign wr_take   = full_n & ~wr_active & (wr_ev.fall | (wr_wait & ~wr_ev.lvl));
  assign wr_commit = wr_active & wr_ev.rise;
  assign rd_take   = empty_n & ~rd_active & (rd_ev.fall | (rd_wait & ~rd_ev.lvl));
  assign rd_done   = rd_active & rd_ev.rise;
  assign rt_go     = rt_armed & rt_ev.rise & rt_ev.lvl & wr_ev.lvl & rd_ev.lvl;

  // write side: claim on fall (or later, when held), store on rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_active <= 1'b0;
      wr_wait   <= 1'b0;
      wr_ptr    <= '0;
    end else begin
      if (wr_take)        wr_active <= 1'b1;
      else if (wr_commit) wr_active <= 1'b0;
      if (wr_ev.fall && !full_n)    wr_wait <= 1'b1;
      else if (wr_take || wr_ev.rise) wr_wait <= 1'b0;
      if (wr_commit) wr_ptr <= wr_ptr + 1'b1;
    end
  end

  // read side: take on fall (or later, when held), release on rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_wait   <= 1'b0;
      rd_ptr    <= '0;
    end else begin
      if (rd_take)      rd_active <= 1'b1;
      else if (rd_done) rd_active <= 1'b0;
      if (rd_ev.fall && !empty_n)    rd_wait <= 1'b1;
      else if (rd_take || rd_ev.rise) rd_wait <= 1'b0;
      if (rt_go)        rd_ptr <= '0;
      else if (rd_take) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // rewind: armed at fall when idle, dropped by any strobe activity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_armed <= 1'b0;
    end else if (rt_ev.fall) begin
      rt_armed <= ~busy & wr_ev.lvl & rd_ev.lvl;
    end else if (busy || !wr_ev.lvl || !rd_ev.lvl || rt_ev.rise) begin
      rt_armed <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             full_n,
  output logic             half_n,
  output logic             empty_n
);
  localparam int AW = $clog2(DEPTH);

  logic [NSTB-1:0] pins;
  strobe_t         ev [NSTB];

  assign pins[STB_WR] = wr_n;
  assign pins[STB_RD] = rd_n;
  assign pins[STB_RT] = rt_n;

  for (genvar g = 0; g < NSTB; g++) begin : g_sync
    fifo_rt_strobe_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (pins[g]),
      .ev    (ev[g])
    );
  end

  logic wr_lvl, rd_lvl, wr_fall, wr_rise, rd_rise;
  assign wr_lvl  = ev[STB_WR].lvl;
  assign rd_lvl  = ev[STB_RD].lvl;
  assign wr_fall = ev[STB_WR].fall;
  assign wr_rise = ev[STB_WR].rise;
  assign rd_rise = ev[STB_RD].rise;

  logic          wr_take, wr_commit, rd_take, rd_done, rt_go, rd_active;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [WIDTH-1:0] rdata;

  fifo_rt_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ev     (ev[STB_WR]),
    .rd_ev     (ev[STB_RD]),
    .rt_ev     (ev[STB_RT]),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .wr_take   (wr_take),
    .wr_commit (wr_commit),
    .rd_take   (rd_take),
    .rd_done   (rd_done),
    .rt_go     (rt_go),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .rd_active (rd_active)
  );

  fifo_rt_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_commit),
    .waddr (wr_ptr),
    .wdata (din),
    .re    (rd_take),
    .raddr (rd_ptr),
    .rdata (rdata)
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_inc  (wr_take),
    .fill_dec  (rd_done),
    .avail_inc (wr_commit),
    .avail_dec (rd_take),
    .rt_load   (rt_go),
    .rt_ptr    (wr_ptr),
    .full_n    (full_n),
    .half_n    (half_n),
    .empty_n   (empty_n)
  );

  assign dout_oe = rd_active;
  assign dout    = rd_active ? rdata : '0;
endmodule

// File: rtl/fifo_rt_checker.sv
module fifo_rt_checker #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dout,
  input logic             dout_oe,
  input logic             full_n,
  input logic             half_n,
  input logic             empty_n,
  input logic             wr_lvl,
  input logic             rd_lvl,
  input logic             wr_fall,
  input logic             wr_rise,
  input logic             rd_rise,
  input logic             rt_go
);
  p_bus_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);
  p_read_needs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(empty_n));
  p_full_consistent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (!half_n && empty_n));
  p_half_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half_n) |-> ($past(wr_fall) || !wr_lvl || $past(rt_go)));
  p_half_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_n) |-> ($past(rd_rise) || $past(rt_go)));
  p_full_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_n) |-> $past(rd_rise));
  p_empty_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_n) |-> ($past(wr_rise) || $past(rt_go)));
  p_rewind_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rt_go |-> (wr_lvl && rd_lvl));
endmodule

bind fifo_rt_ctrl fifo_rt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dout    (dout),
  .dout_oe (dout_oe),
  .full_n  (full_n),
  .half_n  (half_n),
  .empty_n (empty_n),
  .wr_lvl  (wr_lvl),
  .rd_lvl  (rd_lvl),
  .wr_fall (wr_fall),
  .wr_rise (wr_rise),
  .rd_rise (rd_rise),
  .rt_go   (rt_go)
);

// File: tb/fifo_rt_ctrl_bench.sv
module fifo_rt_ctrl_bench;
  localparam int W = 9;
  localparam int D = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_oe, full_n, half_n, empty_n;

  always #10 clk = ~clk;  // 50 MHz

  fifo_rt_ctrl #(.WIDTH(W), .DEPTH(D)) u_fifo_rt_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .full_n(full_n), .half_n(half_n), .empty_n(empty_n)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] flags();
    return {full_n, half_n, empty_n};
  endfunction

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pulse(input logic [W-1:0] d);
    din = d; wr_n = 1'b0; settle(4); wr_n = 1'b1; settle(4);
  endtask

  task automatic rd_check(input string req, input logic [W-1:0] exp);
    rd_n = 1'b0; settle(4);
    chk(req, int'(dout_oe), 1);
    chk(req, int'(dout), int'(exp));
    rd_n = 1'b1; settle(4);
  endtask

  task automatic rt_pulse();
    rt_n = 1'b0; settle(4); rt_n = 1'b1; settle(4);
  endtask

  // {op[1:0], data[8:0], expected read word[8:0], expected flags[2:0]}
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RT = 2'd2;
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {OP_WR, 9'h101, 9'h000, 3'b111},
    {OP_WR, 9'h0A5, 9'h000, 3'b111},
    {OP_WR, 9'h1FF, 9'h000, 3'b111},
    {OP_RD, 9'h000, 9'h101, 3'b111},
    {OP_RD, 9'h000, 9'h0A5, 3'b111},
    {OP_RT, 9'h000, 9'h000, 3'b111},
    {OP_RD, 9'h000, 9'h101, 3'b111},
    {OP_RD, 9'h000, 9'h0A5, 3'b111},
    {OP_RD, 9'h000, 9'h1FF, 3'b110},
    {OP_RT, 9'h000, 9'h000, 3'b111},
    {OP_RD, 9'h000, 9'h101, 3'b111},
    {OP_WR, 9'h033, 9'h000, 3'b111},
    {OP_RD, 9'h000, 9'h0A5, 3'b111},
    {OP_RD, 9'h000, 9'h1FF, 3'b111},
    {OP_RD, 9'h000, 9'h033, 3'b110}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    settle(3);
    chk("R1 flags in reset", int'(flags()), 3'b110);
    chk("R1 oe in reset", int'(dout_oe), 0);
    rst_n = 1'b1; settle(3);
    chk("R1 flags after reset", int'(flags()), 3'b110);

    // vector table: order, rewind (R7), flag table (R4)
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][22:21])
        OP_WR: wr_pulse(VEC[v][20:12]);
        OP_RD: rd_check("R3/R7 read word", VEC[v][11:3]);
        default: rt_pulse();
      endcase
      chk("R4/R7 flags after step", int'(flags()), int'(VEC[v][2:0]));
    end

    // read on empty has no effect (R3)
    rd_n = 1'b0; settle(4);
    chk("R3 no bus on empty read", int'(dout_oe), 0);
    chk("R3 bus zero when idle", int'(dout), 0);
    rd_n = 1'b1; settle(4);
    chk("R3 flags after refused read", int'(flags()), 3'b110);
    wr_pulse(9'h0C3);
    rd_check("R3 pointer kept after refused read", 9'h0C3);

    // read flow-through (R9)
    rd_n = 1'b0; settle(4);
    chk("R9 held read waits", int'(dout_oe), 0);
    wr_pulse(9'h155);
    chk("R9 flow-through enable", int'(dout_oe), 1);
    chk("R9 flow-through word", int'(dout), 9'h155);
    chk("R9 empty after flow-through", int'(flags()), 3'b110);
    wr_pulse(9'h0AA);
    chk("R9 second write does not replace", int'(dout), 9'h155);
    rd_n = 1'b1; settle(4);
    rd_check("R9 next word needs new strobe", 9'h0AA);

    // reset mid-run, then rewind during open read is ignored (R1, R8)
    wr_pulse(9'h077);
    rst_n = 1'b0; settle(2); rst_n = 1'b1; settle(2);
    chk("R1 reset drops contents", int'(flags()), 3'b110);
    wr_pulse(9'h011); wr_pulse(9'h022); wr_pulse(9'h033);
    rd_check("R8 setup read", 9'h011);
    rd_n = 1'b0; settle(4);
    chk("R8 open read word", int'(dout), 9'h022);
    rt_pulse();
    rd_n = 1'b1; settle(4);
    rd_check("R8 rewind ignored while strobe low", 9'h033);

    // fill to full (R4, R5, R6)
    rst_n = 1'b0; settle(2); rst_n = 1'b1; settle(2);
    for (int i = 0; i < D; i++) begin
      din = pat(i); wr_n = 1'b0; settle(4);
      if (i == D/2 - 1) chk("R4 half_n high at 1024", int'(half_n), 1);
      if (i == D/2)     chk("R5 half_n falls on write fall", int'(half_n), 0);
      if (i == D - 2)   chk("R4 full_n high at 2047", int'(full_n), 1);
      if (i == D - 1)   chk("R6 full_n falls on last write fall", int'(full_n), 0);
      wr_n = 1'b1; settle(4);
    end
    chk("R4 flags at 2048", int'(flags()), 3'b001);
    wr_pulse(9'h1FF);  // refused (R2)
    chk("R2 refused write keeps full", int'(flags()), 3'b001);

    // write flow-through (R10)
    din = 9'h1EE; wr_n = 1'b0; settle(4);
    chk("R10 held write blocked", int'(full_n), 0);
    rd_n = 1'b0; settle(4);
    chk("R3 first word out", int'(dout), int'(pat(0)));
    chk("R6 full_n stays low during read", int'(full_n), 0);
    begin
      bit saw_high = 1'b0;
      rd_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (full_n) saw_high = 1'b1;
      end
      chk("R10 full_n blinks after read rise", int'(saw_high), 1);
    end
    chk("R10 full_n reasserted", int'(full_n), 0);
    wr_n = 1'b1; settle(4);
    chk("R10 full after held write", int'(flags()), 3'b001);

    // drain and check order (R2, R3, R5, R6, R10)
    for (int k = 1; k < D; k++) begin
      rd_n = 1'b0; settle(4);
      chk("R3 drain order", int'(dout), int'(pat(k)));
      if (k == D/2) chk("R5 half_n low before read rise", int'(half_n), 0);
      rd_n = 1'b1; settle(4);
      if (k == 1)   chk("R6 full_n high after read rise", int'(full_n), 1);
      if (k == D/2) chk("R5 half_n rises on read rise", int'(half_n), 1);
    end
    rd_n = 1'b0; settle(4);
    chk("R10 held word last", int'(dout), 9'h1EE);
    chk("R6 empty_n falls on last read fall", int'(empty_n), 0);
    rd_n = 1'b1; settle(4);
    chk("R6 flags empty after drain", int'(flags()), 3'b110);
    rd_n = 1'b0; settle(4);
    chk("R2 refused write never stored", int'(dout_oe), 0);
    rd_n = 1'b1; settle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule